// File: doc/BRIEF.md
# GPIO Interrupt and Wake Controller

This block watches a parameterised group of general-purpose pins and turns chosen transitions or levels on them into latched interrupt flags. For each pin the configuration inputs set the direction, whether the pin is a masked-in source, edge or level sensing, the active polarity, and a mode that fires on both edges. Every pin passes through a two-flop synchroniser before its events are detected. Flags latch whether or not interrupts are globally enabled. Software clears them by writing ones.

The controller drives two outputs. The first is an active-high processor interrupt line, which is raised when the global enable is on and at least one masked-in flag is pending. The second is a wake request, which asks board power to switch on while the system is off. A separate first-event register keeps the masked-in events of the first cycle in which any of them appeared. It holds that value until software clears it. Register decoding and debounce delays sit outside the block, so all configuration arrives as plain parallel inputs.

Top module: `gpio_irq_wake_ctrl`

## Requirements
- R1: With synchronous reset low at a clock edge, `raw_o`, `status_o` and `first_o` are zero after that edge, and `cpu_irq_o` and `wake_o` are low while the global enable is low.
- R2: A pin whose `dir_i` bit is 1 (output) never sets a bit in `raw_o`, whatever its input does. A bit of 0 means input.
- R3: In edge mode (`edge_i` bit = 1) with `both_i` bit = 0, a polarity bit of 1 makes a 0-to-1 transition set the flag and a polarity bit of 0 makes a 1-to-0 transition set it. The opposite transition sets nothing.
- R4: In edge mode with the `both_i` bit = 1, either transition sets the flag, regardless of polarity.
- R5: In level mode (`edge_i` bit = 0) the flag is set on every cycle in which the synchronised pin equals its polarity bit. A clear write during that time leaves it set, and a clear write after the level goes inactive removes it.
- R6: A cycle with `status_clr_we_i` high clears exactly the `raw_o` bits where `status_clr_i` is 1. An event on the same bit in the same cycle keeps that bit set.
- R7: `raw_o` shows latched flags regardless of `mask_i`. `status_o` equals `raw_o` AND `mask_i` (mask bit 1 = source enabled).
- R8: While `first_o` is zero it loads the masked-in events of the current cycle. Once it is non-zero it holds. `first_clr_we_i` zeroes it, and that write takes priority over capture.
- R9: `cpu_irq_o` is high exactly when `global_en_i` is high and `status_o` is non-zero. Flags latch even while `global_en_i` is low.
- R10: `wake_o` is high exactly when `cpu_irq_o` is high and `sys_on_i` is low.
- R11: A pin change held steady is reflected in `raw_o` after the third rising clock edge following it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | N_PINS | Asynchronous pin levels |
| dir_i | input | N_PINS | Direction, 1 = output (never a source) |
| mask_i | input | N_PINS | 1 = pin enabled as interrupt source |
| edge_i | input | N_PINS | 1 = edge sensing, 0 = level sensing |
| pol_i | input | N_PINS | 1 = rising / high, 0 = falling / low |
| both_i | input | N_PINS | 1 = edge mode fires on both transitions |
| global_en_i | input | 1 | Global interrupt enable |
| sys_on_i | input | 1 | High while board power is on |
| status_clr_we_i | input | 1 | Strobe for a write-one-to-clear of flags |
| status_clr_i | input | N_PINS | Flags to clear when strobed |
| first_clr_we_i | input | 1 | Strobe that zeroes the first-event register |
| status_o | output | N_PINS | Masked pending flags |
| raw_o | output | N_PINS | Latched flags regardless of mask |
| first_o | output | N_PINS | First-event capture |
| cpu_irq_o | output | 1 | Processor interrupt line |
| wake_o | output | 1 | Power-on request |

## Verification
An error in the synchroniser or edge history shows up as a flag appearing one edge early or late, or as a flag on the wrong transition. The bench sees it on the first clock after the third edge that follows a pin change. A flag latch that mishandles a clear is visible on the very next clock, either as a bit that does not drop or as a level bit that drops while its level is still active. A first-event register that keeps capturing shows a changed `first_o` value at the edge where a later event arrives. A wrong gating of the interrupt or wake outputs is seen in the same cycle that the enable or power input changes.

// File: rtl/gpio_irq_pkg.sv
// Package: shared definitions for the GPIO interrupt and wake controller.
// Holds the per-pin event decision so every pin slice uses one rule.
package gpio_irq_pkg;

    // Sensing modes selected by one configuration bit per pin.
    typedef enum logic {
        SENSE_LEVEL = 1'b0,
        SENSE_EDGE  = 1'b1
    } sense_mode_e;

    // Per-pin configuration gathered into one record.
    typedef struct packed {
        logic        is_out;
        sense_mode_e mode;
        logic        pol;
        logic        both;
    } pin_cfg_t;

    // Decide whether one pin produces an event this cycle.
    // cur and prev are consecutive synchronised samples.
    function automatic logic pin_fires(pin_cfg_t cfg, logic cur, logic prev);
        logic hit;
        hit = 1'b0;
        if (!cfg.is_out) begin
            if (cfg.mode == SENSE_LEVEL) begin
                hit = (cur == cfg.pol);
            end else if (cfg.both) begin
                hit = (cur != prev);
            end else if (cfg.pol) begin
                hit = cur & ~prev;
            end else begin
                hit = ~cur & prev;
            end
        end
        return hit;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
// Module: gpio_irq_sync
// Multi-stage flop chain that brings asynchronous pin levels into the
// clock domain. Assumes each bit is independent (no bus coherency).
// SYNC_STAGES must be at least 2.
module gpio_irq_sync #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [WIDTH-1:0] chain_q [SYNC_STAGES];

    genvar k;
    generate
        for (k = 0; k < SYNC_STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                // First stage: capture the raw pin levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[k] <= '0;
                    else        chain_q[k] <= async_i;
                end
            end else begin : g_next
                // Later stages: shift the sample one step along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[k] <= '0;
                    else        chain_q[k] <= chain_q[k-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/gpio_irq_detect.sv
// Module: gpio_irq_detect
// Keeps the previous synchronised sample of every pin and applies the
// per-pin sensing rule to produce a one-cycle event vector.
// Assumes sync_i is already in the clock domain.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] sync_i,
    input  logic [N_PINS-1:0] dir_i,
    input  logic [N_PINS-1:0] edge_i,
    input  logic [N_PINS-1:0] pol_i,
    input  logic [N_PINS-1:0] both_i,
    output logic [N_PINS-1:0] event_o
);
    logic [N_PINS-1:0] prev_q;

    // Remember the last synchronised sample for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    genvar p;
    generate
        for (p = 0; p < N_PINS; p++) begin : g_pin
            pin_cfg_t cfg;
            // Assemble this pin's configuration record.
            always_comb begin
                cfg.is_out = dir_i[p];
                cfg.mode   = edge_i[p] ? SENSE_EDGE : SENSE_LEVEL;
                cfg.pol    = pol_i[p];
                cfg.both   = both_i[p];
            end
            // Apply the sensing rule to this pin.
            always_comb event_o[p] = pin_fires(cfg, sync_i[p], prev_q[p]);
        end
    endgenerate

    // R2
    output_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((event_o & dir_i) == '0));

endmodule

// File: rtl/gpio_irq_latch.sv
// Module: gpio_irq_latch
// Holds the latched flag vector (set by events, cleared by writing ones)
// and the first-event capture register. Assumes events are one-cycle or
// level pulses from gpio_irq_detect. Set wins over clear on a bit.
module gpio_irq_latch #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] event_i,
    input  logic [N_PINS-1:0] mask_i,
    input  logic              clr_we_i,
    input  logic [N_PINS-1:0] clr_i,
    input  logic              first_clr_we_i,
    output logic [N_PINS-1:0] raw_o,
    output logic [N_PINS-1:0] first_o
);
    logic [N_PINS-1:0] raw_q;
    logic [N_PINS-1:0] first_q;
    logic [N_PINS-1:0] clr_eff;
    logic              first_empty;

    // Bits to drop this cycle, only when the strobe is present.
    always_comb clr_eff = clr_we_i ? clr_i : '0;

    // First-event register is open for capture only while empty.
    always_comb first_empty = (first_q == '0);

    // Latch events; a write of ones removes flags unless re-set now.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_eff) | event_i;
    end

    // Capture the masked events of the first active cycle, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)             first_q <= '0;
        else if (first_clr_we_i) first_q <= '0;
        else if (first_empty)    first_q <= event_i & mask_i;
    end

    assign raw_o   = raw_q;
    assign first_o = first_q;

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((raw_q & $past(clr_i) & ~$past(event_i)) == '0));

    // R8
    first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_empty && !first_clr_we_i) |=> (first_q == $past(first_q)));

    // R8
    first_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_clr_we_i |=> (first_q == '0));

endmodule

// File: rtl/gpio_irq_wake_ctrl.sv
// Module: gpio_irq_wake_ctrl (top)
// GPIO interrupt and wake controller: synchronises pins, detects
// configured events, latches flags and drives the processor interrupt
// and power-on request. Configuration inputs are assumed to be static
// register outputs in the same clock domain; pins may be asynchronous.
module gpio_irq_wake_ctrl #(
    parameter int N_PINS      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic [N_PINS-1:0] dir_i,
    input  logic [N_PINS-1:0] mask_i,
    input  logic [N_PINS-1:0] edge_i,
    input  logic [N_PINS-1:0] pol_i,
    input  logic [N_PINS-1:0] both_i,
    input  logic              global_en_i,
    input  logic              sys_on_i,
    input  logic              status_clr_we_i,
    input  logic [N_PINS-1:0] status_clr_i,
    input  logic              first_clr_we_i,
    output logic [N_PINS-1:0] status_o,
    output logic [N_PINS-1:0] raw_o,
    output logic [N_PINS-1:0] first_o,
    output logic              cpu_irq_o,
    output logic              wake_o
);
    logic [N_PINS-1:0] pin_sync;
    logic [N_PINS-1:0] pin_event;
    logic [N_PINS-1:0] raw_flags;
    logic              any_pending;

    gpio_irq_sync #(.WIDTH(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    gpio_irq_detect #(.N_PINS(N_PINS)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (pin_sync),
        .dir_i   (dir_i),
        .edge_i  (edge_i),
        .pol_i   (pol_i),
        .both_i  (both_i),
        .event_o (pin_event)
    );

    gpio_irq_latch #(.N_PINS(N_PINS)) u_latch (
        .clk            (clk),
        .rst_n          (rst_n),
        .event_i        (pin_event),
        .mask_i         (mask_i),
        .clr_we_i       (status_clr_we_i),
        .clr_i          (status_clr_i),
        .first_clr_we_i (first_clr_we_i),
        .raw_o          (raw_flags),
        .first_o        (first_o)
    );

    // Masked view and pending summary.
    always_comb begin
        status_o    = raw_flags & mask_i;
        any_pending = |status_o;
    end

    // Interrupt gated by global enable; wake only while power is off.
    always_comb begin
        cpu_irq_o = global_en_i & any_pending;
        wake_o    = cpu_irq_o & ~sys_on_i;
    end

    assign raw_o = raw_flags;

    // R2
    dir_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_flags & ~$past(raw_flags) & $past(dir_i)) == '0));

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en_i |-> !cpu_irq_o);

    // R10
    wake_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (!sys_on_i && global_en_i && (raw_flags & mask_i) != '0));

endmodule

// File: tb/sim_gpio_irq_wake_ctrl.sv
// Bench: behavioural reference model compared every clock, plus
// directed checks for each requirement.
module sim_gpio_irq_wake_ctrl;
    localparam int N  = 8;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] pin, dir, mask, edg, pol, both, clr;
    logic         gen, sys_on, clr_we, fclr;
    logic [N-1:0] status, raw, first;
    logic         irq, wake;

    int checks = 0;
    int bad    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_wake_ctrl #(.N_PINS(N), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .dir_i(dir), .mask_i(mask),
        .edge_i(edg), .pol_i(pol), .both_i(both), .global_en_i(gen),
        .sys_on_i(sys_on), .status_clr_we_i(clr_we), .status_clr_i(clr),
        .first_clr_we_i(fclr), .status_o(status), .raw_o(raw),
        .first_o(first), .cpu_irq_o(irq), .wake_o(wake)
    );

    // Reference model: pin history kept in a queue, newest first.
    logic [N-1:0] hist[$];
    logic [N-1:0] m_raw, m_first;

    always @(posedge clk) begin
        logic [N-1:0] ev;
        if (!rst_n) begin
            hist    = {'0, '0, '0};
            m_raw   = '0;
            m_first = '0;
        end else begin
            ev = '0;
            for (int i = 0; i < N; i++) begin
                logic now_v, old_v;
                now_v = hist[1][i];
                old_v = hist[2][i];
                if (dir[i]) ev[i] = 1'b0;
                else if (!edg[i]) ev[i] = (now_v == pol[i]);
                else if (both[i]) ev[i] = (now_v != old_v);
                else if (pol[i]) ev[i] = (!old_v && now_v);
                else ev[i] = (old_v && !now_v);
            end
            if (fclr) m_first = '0;
            else if (m_first == '0) m_first = ev & mask;
            if (clr_we) m_raw = m_raw & ~clr;
            m_raw = m_raw | ev;
            hist.push_front(pin);
            void'(hist.pop_back());
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model.
    task automatic compare_model();
        logic m_irq;
        m_irq = gen && ((m_raw & mask) != '0);
        chk("R7 raw", 32'(raw), 32'(m_raw));
        chk("R7 status", 32'(status), 32'(m_raw & mask));
        chk("R8 first", 32'(first), 32'(m_first));
        chk("R9 irq", 32'(irq), 32'(m_irq));
        chk("R10 wake", 32'(wake), 32'(m_irq && !sys_on));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) compare_model();
    endtask

    task automatic settle();
        repeat (4) tick();
    endtask

    task automatic clear_flags(input logic [N-1:0] bits);
        clr = bits; clr_we = 1'b1;
        tick();
        clr_we = 1'b0; clr = '0;
    endtask

    task automatic clear_first();
        fclr = 1'b1;
        tick();
        fclr = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; pin = '0; dir = '0; mask = 8'h01; edg = 8'hF7;
        pol = 8'hFD; both = 8'h04; clr = '0; gen = 1'b0; sys_on = 1'b0;
        clr_we = 1'b0; fclr = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 raw", 32'(raw), 0);
        chk("R1 first", 32'(first), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 wake", 32'(wake), 0);

        // R11 latency and R3 rising edge on pin 0
        pin[0] = 1'b1;
        tick(); tick();
        chk("R11 early", 32'(raw[0]), 0);
        tick();
        chk("R11 third edge", 32'(raw[0]), 1);
        chk("R3 rising", 32'(raw[0]), 1);
        chk("R9 latched no irq", 32'(irq), 0);
        gen = 1'b1;
        tick();
        chk("R9 irq on", 32'(irq), 1);
        chk("R10 wake power off", 32'(wake), 1);
        sys_on = 1'b1;
        tick();
        chk("R10 wake power on", 32'(wake), 0);
        chk("R8 first pin0", 32'(first), 32'h01);
        clear_flags(8'h01);
        chk("R6 cleared", 32'(raw), 0);
        chk("R9 irq off", 32'(irq), 0);

        // R2 output pin never fires
        mask = 8'hBF; dir[5] = 1'b1;
        pin[5] = 1'b1; settle();
        pin[5] = 1'b0; settle();
        chk("R2 output pin", 32'(raw[5]), 0);

        // R7 unmasked pin 6 latches in raw only
        pin[6] = 1'b1; settle();
        chk("R7 raw bit", 32'(raw[6]), 1);
        chk("R7 status bit", 32'(status[6]), 0);

        // R3 falling polarity on pin 1
        pin[1] = 1'b1; settle();
        chk("R3 wrong edge", 32'(raw[1]), 0);
        pin[1] = 1'b0; settle();
        chk("R3 falling", 32'(raw[1]), 1);

        // R6 selective clear
        clear_flags(8'h40);
        chk("R6 only bit6", 32'(raw), 32'h02);
        clear_flags(8'h02);

        // R4 both edges on pin 2
        pin[2] = 1'b1; settle();
        chk("R4 rise", 32'(raw[2]), 1);
        clear_flags(8'h04);
        chk("R4 cleared", 32'(raw[2]), 0);
        pin[2] = 1'b0; settle();
        chk("R4 fall", 32'(raw[2]), 1);
        clear_flags(8'h04);

        // R5 level high on pin 3
        pin[3] = 1'b1; settle();
        chk("R5 level set", 32'(raw[3]), 1);
        clear_flags(8'h08);
        chk("R5 clear while active", 32'(raw[3]), 1);
        pin[3] = 1'b0; settle();
        chk("R5 held after inactive", 32'(raw[3]), 1);
        clear_flags(8'h08);
        chk("R5 clear after inactive", 32'(raw[3]), 0);

        // R8 first-event capture order
        pin[0] = 1'b0; settle();
        clear_first();
        chk("R8 wiped", 32'(first), 0);
        pin[7] = 1'b1; settle();
        pin[0] = 1'b1; settle();
        chk("R8 earliest only", 32'(first), 32'h80);
        pin[0] = 1'b0; pin[7] = 1'b0; settle();
        clear_first();
        pin[0] = 1'b1; pin[7] = 1'b1; settle();
        chk("R8 same cycle", 32'(first), 32'h81);

        // R9 global disable drops the line, flags stay
        gen = 1'b0; sys_on = 1'b0;
        tick();
        chk("R9 disabled", 32'(irq), 0);
        chk("R10 no wake when disabled", 32'(wake), 0);
        chk("R9 flags kept", 32'(raw & 8'h81), 32'h81);

        // R1 reset mid-run
        rst_n = 1'b0;
        tick();
        chk("R1 re-reset raw", 32'(raw), 0);
        chk("R1 re-reset first", 32'(first), 0);
        rst_n = 1'b1;
        settle();
        finish_run();
    end
endmodule